// File: doc/BRIEF.md
# Dual-Modulus Swallow Feedback Divider

This block divides a fast input clock by a programmable ratio using a prescaler that divides by 8 or by 9, a swallow counter that chooses between the two, and a main counter that counts prescaler periods. An 11-bit divide word holds the main count M in its upper eight bits and the swallow count A in its lower three bits. The resulting ratio is 8·M + A. In each divider cycle the prescaler first runs A periods of nine input clocks and then runs M − A periods of eight.

New divide words come in on a one-clock load strobe. A word is checked when it arrives: a word with M = 0 or with A > M raises an error pulse and is discarded. A legal word waits in a shadow register and only replaces the running word when the current cycle ends, so no output period is ever cut short. Each completed cycle produces a registered pulse that is one input clock wide. A build option replaces the pulse with a clock that toggles on every completion. The block sits in the feedback path of a frequency synthesiser, and its pulse is compared against the reference.

Top module: `fbdiv_swallow`

## Requirements
- R1: With word[10:3] = M and word[2:0] = A, the distance between consecutive output pulses is exactly 8·M + A input clocks.
- R2: With A = 0 the ratio is exactly 8·M. With A = M every prescaler period lasts nine clocks and the ratio is 9·M.
- R3: An accepted word takes effect only at the next cycle boundary. The cycle in progress completes with the old ratio. When several legal words are loaded within one cycle, the last one governs the next cycle.
- R4: Every ratio from 8 (word value 8) up to 2047 (all bits set) is produced when legal. No output period is shorter than 8 or longer than 2047 clocks.
- R5: In pulse mode the output is high for exactly one clock per cycle. It rises on the clock edge that completes the cycle.
- R6: A word loaded with M = 0 or A > M makes the error output high for the one clock after the load edge, and the output period stays unchanged. A legal load leaves the error output low.
- R7: While reset is low, the output and the error output are low. The running word is the reset word (default 26: M = 3, A = 2). The first pulse rises on the 26th rising edge after reset is released.
- R8: A change on the word input without the load strobe has no effect on the output period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_word | input | 11 | Divide word: [10:3] main count M, [2:0] swallow count A |
| div_load | input | 1 | Strobe: sample div_word on this edge |
| div_out | output | 1 | One-clock pulse per completed cycle (or toggling clock) |
| word_err | output | 1 | High for one clock after an illegal word was loaded |

## Verification
The error flag is due in the clock right after the load edge, so the bench samples it at the first falling edge that follows the strobe. A pulse registered on the completing edge is visible at the falling edge after that rising edge. The bench therefore counts falling edges from one observed pulse to the next and compares the count with 8·M + A. Each new word is loaded just after a pulse. The interval that follows must still equal the old ratio, and only the next two intervals must equal the new one. After reset is released, the count starts at the first falling edge, and the first pulse must arrive at count 26.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;
   // output flavour of the divider
   typedef enum logic {
      OUT_PULSE  = 1'b0,   // one input-clock-wide pulse per cycle
      OUT_TOGGLE = 1'b1    // toggle on each cycle completion
   } out_style_e;
endpackage

// File: rtl/fbdiv_word_ctl.sv
// Divide-word checking, shadow register and running word.
module fbdiv_word_ctl #(
   parameter int unsigned M_W      = 8,
   parameter int unsigned A_W      = 3,
   parameter int unsigned RST_WORD = 26
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [M_W+A_W-1:0]       word,
   input  logic                     bound,
   output logic [M_W-1:0]           nxt_m,
   output logic [A_W-1:0]           nxt_a,
   output logic                     err
);
   localparam int unsigned WW = M_W + A_W;
   localparam logic [WW-1:0]  RST_VEC = WW'(RST_WORD);
   localparam logic [M_W-1:0] RST_M   = RST_VEC[WW-1:A_W];
   localparam logic [A_W-1:0] RST_A   = RST_VEC[A_W-1:0];

   logic [M_W-1:0] w_m;
   logic [A_W-1:0] w_a;
   logic           legal;
   logic [M_W-1:0] act_m, pend_m;
   logic [A_W-1:0] act_a, pend_a;
   logic           pend_vld;

   assign w_m   = word[WW-1:A_W];
   assign w_a   = word[A_W-1:0];
   assign legal = (w_m != '0) && (M_W'(w_a) <= w_m);

   // next cycle uses the pending word when one waits
   always_comb begin
      if (pend_vld) begin
         nxt_m = pend_m;
         nxt_a = pend_a;
      end else begin
         nxt_m = act_m;
         nxt_a = act_a;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_m   <= RST_M;
         pend_a   <= RST_A;
         pend_vld <= 1'b0;
      end else if (load && legal) begin
         pend_m   <= w_m;
         pend_a   <= w_a;
         pend_vld <= 1'b1;
      end else if (bound) begin
         pend_vld <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_m <= RST_M;
         act_a <= RST_A;
      end else if (bound) begin
         act_m <= nxt_m;
         act_a <= nxt_a;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err <= 1'b0;
      else        err <= load && !legal;
   end
endmodule

// File: rtl/fbdiv_prescaler.sv
// Dual-modulus prescaler: 2**A_W or 2**A_W + 1 input clocks per period.
module fbdiv_prescaler #(
   parameter int unsigned A_W     = 3,
   parameter bit          RST_EXT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ext_next,   // next period is the long one
   output logic tc
);
   localparam int unsigned PW   = A_W + 1;
   localparam logic [PW-1:0] N_HI = PW'(1) << A_W;   // long period - 1
   localparam logic [PW-1:0] N_LO = N_HI - PW'(1);   // short period - 1

   logic [PW-1:0] pcnt;

   assign tc = (pcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  pcnt <= RST_EXT ? N_HI : N_LO;
      else if (tc) pcnt <= ext_next ? N_HI : N_LO;
      else         pcnt <= pcnt - PW'(1);
   end
endmodule

// File: rtl/fbdiv_swallow_ctr.sv
// Counts the long prescaler periods left in the current cycle.
module fbdiv_swallow_ctr #(
   parameter int unsigned A_W   = 3,
   parameter int unsigned RST_A = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tc,
   input  logic           bound,
   input  logic [A_W-1:0] load_a,
   output logic           ext_next
);
   logic [A_W-1:0] acnt;
   logic [A_W-1:0] acnt_dec;

   assign acnt_dec = (acnt != '0) ? acnt - A_W'(1) : acnt;
   assign ext_next = bound ? (load_a != '0) : (acnt_dec != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acnt <= A_W'(RST_A);
      else if (bound)  acnt <= load_a;
      else if (tc)     acnt <= acnt_dec;
   end
endmodule

// File: rtl/fbdiv_main_ctr.sv
// Counts prescaler periods; its terminal count closes the divider cycle.
module fbdiv_main_ctr #(
   parameter int unsigned M_W   = 8,
   parameter int unsigned RST_M = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           tc,
   input  logic [M_W-1:0] load_m,
   output logic           bound
);
   logic [M_W-1:0] mcnt;

   assign bound = tc && (mcnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mcnt <= M_W'(RST_M) - M_W'(1);
      else if (bound)  mcnt <= load_m - M_W'(1);
      else if (tc)     mcnt <= mcnt - M_W'(1);
   end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow
   import fbdiv_pkg::*;
#(
   parameter int unsigned M_W       = 8,
   parameter int unsigned A_W       = 3,
   parameter int unsigned RST_WORD  = 26,
   parameter out_style_e  OUT_STYLE = OUT_PULSE
) (
   input  logic                 clk_in,
   input  logic                 rst_n,
   input  logic [M_W+A_W-1:0]   div_word,
   input  logic                 div_load,
   output logic                 div_out,
   output logic                 word_err
);
   localparam int unsigned WW    = M_W + A_W;
   localparam int unsigned RST_M = RST_WORD >> A_W;
   localparam int unsigned RST_A = RST_WORD % (1 << A_W);

   // elaboration-time parameter checks
   if (A_W < 1 || M_W < A_W) begin : g_bad_width
      $error("fbdiv_swallow: need A_W >= 1 and M_W >= A_W");
   end
   if (RST_M == 0 || RST_A > RST_M || RST_WORD >= (1 << WW)) begin : g_bad_rst
      $error("fbdiv_swallow: reset word must be legal (M != 0, A <= M)");
   end

   logic           tc, bound, ext_next;
   logic [M_W-1:0] nxt_m;
   logic [A_W-1:0] nxt_a;

   fbdiv_word_ctl #(.M_W(M_W), .A_W(A_W), .RST_WORD(RST_WORD)) u_word (
      .clk   (clk_in),
      .rst_n (rst_n),
      .load  (div_load),
      .word  (div_word),
      .bound (bound),
      .nxt_m (nxt_m),
      .nxt_a (nxt_a),
      .err   (word_err)
   );

   fbdiv_prescaler #(.A_W(A_W), .RST_EXT(RST_A != 0)) u_pre (
      .clk      (clk_in),
      .rst_n    (rst_n),
      .ext_next (ext_next),
      .tc       (tc)
   );

   fbdiv_swallow_ctr #(.A_W(A_W), .RST_A(RST_A)) u_swl (
      .clk      (clk_in),
      .rst_n    (rst_n),
      .tc       (tc),
      .bound    (bound),
      .load_a   (nxt_a),
      .ext_next (ext_next)
   );

   fbdiv_main_ctr #(.M_W(M_W), .RST_M(RST_M)) u_main (
      .clk    (clk_in),
      .rst_n  (rst_n),
      .tc     (tc),
      .load_m (nxt_m),
      .bound  (bound)
   );

   if (OUT_STYLE == OUT_PULSE) begin : g_pulse
      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n) div_out <= 1'b0;
         else        div_out <= bound;
      end
   end else begin : g_toggle
      always_ff @(posedge clk_in or negedge rst_n) begin
         if (!rst_n)     div_out <= 1'b0;
         else if (bound) div_out <= ~div_out;
      end
   end
endmodule

// File: rtl/fbdiv_swallow_chk.sv
module fbdiv_swallow_chk
   import fbdiv_pkg::*;
#(
   parameter int unsigned M_W       = 8,
   parameter int unsigned A_W       = 3,
   parameter out_style_e  OUT_STYLE = OUT_PULSE
) (
   input logic               clk_in,
   input logic               rst_n,
   input logic [M_W+A_W-1:0] div_word,
   input logic               div_load,
   input logic               div_out,
   input logic               word_err
);
   localparam int unsigned WW    = M_W + A_W;
   localparam int unsigned MIN_R = 1 << A_W;
   localparam int unsigned MAX_R = (1 << WW) - 1;

   logic [M_W-1:0] c_m;
   logic [A_W-1:0] c_a;
   logic           c_bad;
   logic [WW:0]    gap;

   assign c_m   = div_word[WW-1:A_W];
   assign c_a   = div_word[A_W-1:0];
   assign c_bad = (c_m == '0) || (M_W'(c_a) > c_m);

   // clocks since reset or since the last output pulse
   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n)                 gap <= '0;
      else if (div_out)           gap <= (WW+1)'(1);
      else if (gap != '1)         gap <= gap + (WW+1)'(1);
   end

   // R6: illegal load is flagged in the following clock
   p_err_flag_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
      (div_load && c_bad) |=> word_err);

   // R6: legal load or no load leaves the flag low
   p_err_quiet_r6: assert property (@(posedge clk_in) disable iff (!rst_n)
      !(div_load && c_bad) |=> !word_err);

   if (OUT_STYLE == OUT_PULSE) begin : g_pulse_chk
      // R5: a pulse is never longer than one clock
      p_pulse_single_r5: assert property (@(posedge clk_in) disable iff (!rst_n)
         div_out |=> !div_out);

      // R4: no period shorter than the minimum ratio
      p_min_period_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
         div_out |-> (gap >= (WW+1)'(MIN_R)));

      // R4: no period longer than the maximum ratio
      p_max_period_r4: assert property (@(posedge clk_in) disable iff (!rst_n)
         gap <= (WW+1)'(MAX_R));
   end
endmodule

bind fbdiv_swallow fbdiv_swallow_chk #(
   .M_W(M_W), .A_W(A_W), .OUT_STYLE(OUT_STYLE)
) u_chk (
   .clk_in   (clk_in),
   .rst_n    (rst_n),
   .div_word (div_word),
   .div_load (div_load),
   .div_out  (div_out),
   .word_err (word_err)
);

// File: tb/fbdiv_swallow_tb_top.sv
`timescale 1ns/1ps
module fbdiv_swallow_tb_top;
   logic        clk_in = 1'b0;
   logic        rst_n;
   logic [10:0] div_word;
   logic        div_load;
   logic        div_out;
   logic        word_err;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #5 clk_in = ~clk_in;

   fbdiv_swallow dut_i (
      .clk_in   (clk_in),
      .rst_n    (rst_n),
      .div_word (div_word),
      .div_load (div_load),
      .div_out  (div_out),
      .word_err (word_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Counts falling edges until div_out is seen high. Clears a pending load
   // strobe after one edge; optionally issues a second load at count 2.
   task automatic wait_pulse(output int n, output int err1, input int second);
      n = 0; err1 = 0;
      do begin
         @(negedge clk_in);
         n++;
         if (n == 1) begin
            err1 = int'(word_err);
            div_load = 1'b0;
         end
         if (n == 2 && second >= 0) begin
            div_word = 11'(second);
            div_load = 1'b1;
         end
         if (n == 3 && second >= 0) div_load = 1'b0;
      end while (!div_out && n < 5000);
   endtask

   function automatic int ratio(input int w);
      return (w >> 3) * 8 + (w & 7);
   endfunction

   int cur;

   task automatic run_word(input int w, input string req);
      int n, e;
      div_word = 11'(w);
      div_load = 1'b1;
      wait_pulse(n, e, -1);
      check(n == cur, "R3 old ratio completes", n, cur);
      check(e == 0, "R6 legal word not flagged", e, 0);
      wait_pulse(n, e, -1);
      check(n == ratio(w), req, n, ratio(w));
      wait_pulse(n, e, -1);
      check(n == ratio(w), req, n, ratio(w));
      cur = ratio(w);
   endtask

   task automatic run_bad(input int w);
      int n, e;
      div_word = 11'(w);
      div_load = 1'b1;
      wait_pulse(n, e, -1);
      check(e == 1, "R6 illegal word flagged", e, 1);
      check(n == cur, "R6 period unchanged", n, cur);
      wait_pulse(n, e, -1);
      check(n == cur, "R6 illegal word discarded", n, cur);
   endtask

   initial begin
      #2000000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      if (!done) begin
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      int n, e;
      int big[8] = '{56, 57, 63, 64, 255, 1000, 1031, 2047};
      rst_n = 1'b0; div_load = 1'b0; div_word = 11'd8;
      repeat (3) @(negedge clk_in);
      // R7: reset state
      check(div_out == 1'b0, "R7 div_out low in reset", int'(div_out), 0);
      check(word_err == 1'b0, "R7 word_err low in reset", int'(word_err), 0);
      rst_n = 1'b1;
      wait_pulse(n, e, -1);
      check(n == 26, "R7 first pulse after reset", n, 26);
      cur = 26;
      @(negedge clk_in);
      check(div_out == 1'b0, "R5 pulse one clock wide", int'(div_out), 0);
      wait_pulse(n, e, -1);
      check(n == 25, "R7 reset word period", n + 1, 26);

      // R8: word change without load has no effect
      div_word = 11'd100;
      wait_pulse(n, e, -1);
      check(n == 26, "R8 unloaded word ignored", n, 26);
      div_word = 11'd2047;
      wait_pulse(n, e, -1);
      check(n == 26, "R8 unloaded word ignored", n, 26);

      // R1/R2: sweep of small legal words
      for (int m = 1; m <= 8; m++) begin
         for (int a = 0; a <= ((m < 7) ? m : 7); a++) begin
            if (m * 8 + a == 8)     run_word(8, "R4 minimum ratio 8");
            else if (a == 0 || a == m) run_word(m * 8 + a, "R2 ratio 8M or 9M");
            else                    run_word(m * 8 + a, "R1 ratio 8M+A");
         end
      end

      // R1/R4: larger ratios up to the maximum
      foreach (big[i]) begin
         if (big[i] == 2047) run_word(big[i], "R4 maximum ratio 2047");
         else                run_word(big[i], "R1 ratio 8M+A");
      end
      run_word(90, "R1 ratio 8M+A");

      // R6: illegal words (M = 0, A > M)
      run_bad(3);
      run_bad(0);
      run_bad(21);

      // R3: two loads in one cycle, last one wins
      div_word = 11'd100;
      div_load = 1'b1;
      wait_pulse(n, e, 77);
      check(n == cur, "R3 old ratio completes", n, cur);
      wait_pulse(n, e, -1);
      check(n == ratio(77), "R3 last load wins", n, ratio(77));
      wait_pulse(n, e, -1);
      check(n == ratio(77), "R3 last load wins", n, ratio(77));

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule